// File: doc/BRIEF.md
# External Interrupt Edge Capture and Wake Controller

This block sits between four external interrupt pins and the core of a small microcontroller. While the core runs or idles, it synchronizes each pin and samples it only in the phase-2 half of the state clock. It turns a rising edge into a pending bit that stays set until the core acknowledges it. If a new edge meets an acknowledge in the same cycle, the new edge wins.

In the two deep power-saving modes (standby and powerdown) the edge path is switched off. A per-pin duration counter then watches each pin that is configured as a special-function input. A pin that stays high for a minimum number of fast-clock cycles raises a wake request, whether or not its interrupt is enabled. The controller also tells the core how to resume. If an enabled pin caused the wake, the core runs the service routine and that pin's pending bit is set. Otherwise the core simply continues after the instruction that entered the power-saving mode. In idle, any pending and enabled interrupt wakes the core.

Top module: `ext_irq_wake`

## Requirements
- R1: While reset is asserted and right after it, `pend`, `wake_req` and `resume_isr` are all zero.
- R2: In run (`pmode`=0) or idle (`pmode`=1), a raw pin that rises passes through a two-flop synchronizer. The synchronized rise is compared with the last phase-2 sample. If `phase2` is high in the cycle where the synchronized value is first high, `pend[i]` rises at the third rising clock edge after the raw change.
- R3: Pins are sampled only in cycles with `phase2` high. A pulse whose synchronized high never coincides with `phase2` high sets nothing, and an edge is judged against the previous phase-2 sample.
- R4: A one-cycle `ack[i]` clears `pend[i]` at the next edge. If a set for the same bit occurs in that cycle, the bit stays set.
- R5: In standby (`pmode`=2) or powerdown (`pmode`=3), a pin with `sfin_cfg[i]`=1 whose synchronized value stays high for `WAKE_CYC` consecutive cycles raises `wake_req`. Any low cycle restarts the count, and `irq_en` has no effect on the wake.
- R6: In the deep modes, a pin with `sfin_cfg[i]`=0 never causes a wake, however long it is held high.
- R7: On a deep-mode wake, `resume_isr` is high only if a waking pin has `irq_en[i]`=1, and each such enabled waking pin sets its pending bit. With only disabled waking pins, `resume_isr` stays low and no pending bit is set.
- R8: In idle, `wake_req` and `resume_isr` are both high exactly when some bit of `pend & irq_en` is high. In run mode both are low.
- R9: In the deep modes no edge sets a pending bit, and the edge sample follows the synchronized pin every cycle. A pin still high on return to run therefore creates no new pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_raw | input | NP | Raw external interrupt pins |
| sfin_cfg | input | NP | Pin configured as special-function input |
| irq_en | input | NP | Per-interrupt enable |
| phase2 | input | 1 | High during phase 2 of the state clock |
| pmode | input | 2 | 0 run, 1 idle, 2 standby, 3 powerdown |
| ack | input | NP | One-cycle pending clear from the core |
| pend | output | NP | Interrupt pending bits |
| wake_req | output | 1 | Request to resume normal operation |
| resume_isr | output | 1 | 1: service interrupt on resume, 0: continue with next instruction |

## Verification
Directed pulses aligned with and against `phase2` separate true phase-2 sampling from sampling on every clock. A rise with acknowledge in the same cycle shows which of set and clear takes priority. In the deep modes, pins are held for one cycle less than, and exactly, the wake duration, with and without the special-function configuration and the enable. These cases separate a counter that is one cycle off, a count that fails to restart on a low cycle, and an enable that wrongly gates the wake. Long constrained-random runs then mix mode changes, acknowledges and pin activity of random duration, which exposes stale samples on return from deep modes.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    PM_RUN       = 2'd0,
    PM_IDLE      = 2'd1,
    PM_STANDBY   = 2'd2,
    PM_POWERDOWN = 2'd3
  } pmode_t;

  function automatic logic is_deep(input logic [1:0] m);
    return (m == PM_STANDBY) || (m == PM_POWERDOWN);
  endfunction

  function automatic logic is_idle(input logic [1:0] m);
    return m == PM_IDLE;
  endfunction
endpackage

// File: rtl/eiw_sync.sv
module eiw_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else             chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/eiw_edge.sv
module eiw_edge #(
  parameter int NP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phase2,
  input  logic          deep,
  input  logic [NP-1:0] pin_s,
  output logic [NP-1:0] rise
);
  logic [NP-1:0] smp_q;

  // Deep modes: track every cycle so no stale low remains on exit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                smp_q <= '0;
    else if (deep || phase2)   smp_q <= pin_s;
  end

  assign rise = (!deep && phase2) ? (pin_s & ~smp_q) : '0;
endmodule

// File: rtl/eiw_deep_timer.sv
module eiw_deep_timer #(
  parameter int NP       = 4,
  parameter int WAKE_CYC = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          deep,
  input  logic [NP-1:0] pin_s,
  input  logic [NP-1:0] cfg,
  output logic [NP-1:0] held
);
  localparam int CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WAKE_CYC);

  function automatic logic [CW-1:0] step(input logic [CW-1:0] c, input logic hi);
    if (!hi)         return '0;
    if (c == LIMIT)  return c;
    return c + 1'b1;
  endfunction

  generate
    for (genvar i = 0; i < NP; i++) begin : g_pin
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= step(cnt_q, deep && cfg[i] && pin_s[i]);
      end
      assign held[i] = deep && (cnt_q == LIMIT);
    end
  endgenerate
endmodule

// File: rtl/ext_irq_wake.sv
module ext_irq_wake
  import ext_irq_pkg::*;
#(
  parameter int NP          = 4,
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_CYC    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] pin_raw,
  input  logic [NP-1:0] sfin_cfg,
  input  logic [NP-1:0] irq_en,
  input  logic          phase2,
  input  logic [1:0]    pmode,
  input  logic [NP-1:0] ack,
  output logic [NP-1:0] pend,
  output logic          wake_req,
  output logic          resume_isr
);
  logic          deep;
  logic          idle;
  logic [NP-1:0] pin_sync;
  logic [NP-1:0] rise_vec;
  logic [NP-1:0] held_vec;
  logic [NP-1:0] set_vec;
  logic [NP-1:0] pend_q;

  assign deep = is_deep(pmode);
  assign idle = is_idle(pmode);

  eiw_sync #(.W(NP), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_sync)
  );

  eiw_edge #(.NP(NP)) u_edge (
    .clk(clk), .rst_n(rst_n), .phase2(phase2), .deep(deep),
    .pin_s(pin_sync), .rise(rise_vec)
  );

  eiw_deep_timer #(.NP(NP), .WAKE_CYC(WAKE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .deep(deep), .pin_s(pin_sync),
    .cfg(sfin_cfg), .held(held_vec)
  );

  assign set_vec = deep ? (held_vec & irq_en) : rise_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~ack) | set_vec;
  end

  assign pend = pend_q;

  always_comb begin
    wake_req   = 1'b0;
    resume_isr = 1'b0;
    if (deep) begin
      wake_req   = |held_vec;
      resume_isr = |(held_vec & irq_en);
    end else if (idle) begin
      wake_req   = |(pend_q & irq_en);
      resume_isr = wake_req;
    end
  end
endmodule

// File: rtl/eiw_checker.sv
module eiw_checker #(
  parameter int NP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    pmode,
  input logic          phase2,
  input logic [NP-1:0] ack,
  input logic [NP-1:0] sfin_cfg,
  input logic [NP-1:0] pin_sync,
  input logic [NP-1:0] set_vec,
  input logic [NP-1:0] pend,
  input logic          wake_req,
  input logic          resume_isr
);
  p_set_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((pend & $past(set_vec)) == $past(set_vec)));

  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack & ~set_vec)) |=> ((pend & $past(ack & ~set_vec)) == '0));

  p_no_sample_off_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase2 && pmode < 2'd2) |=> ((pend & ~$past(pend)) == '0));

  p_run_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pmode == 2'd0) |-> (!wake_req && !resume_isr));

  p_deep_cfg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pmode >= 2'd2 && wake_req) |-> (|(sfin_cfg & pin_sync) || $past(|(sfin_cfg & pin_sync))));

  p_resume_needs_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resume_isr |-> wake_req);
endmodule

bind ext_irq_wake eiw_checker #(.NP(NP)) u_chk (
  .clk(clk), .rst_n(rst_n), .pmode(pmode), .phase2(phase2), .ack(ack),
  .sfin_cfg(sfin_cfg), .pin_sync(pin_sync), .set_vec(set_vec),
  .pend(pend), .wake_req(wake_req), .resume_isr(resume_isr)
);

// File: tb/ext_irq_wake_bench.sv
`timescale 1ns/1ps
module ext_irq_wake_bench;
  localparam int NP = 4;
  localparam int WC = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_raw = '0, sfin_cfg = '0, irq_en = '0, ack = '0;
  logic          phase2 = 1'b0;
  logic [1:0]    pmode = 2'd0;
  logic [NP-1:0] pend;
  logic          wake_req, resume_isr;

  int vectors = 0;
  int miscompares = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  ext_irq_wake #(.NP(NP), .WAKE_CYC(WC)) u_ext_irq_wake (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .sfin_cfg(sfin_cfg),
    .irq_en(irq_en), .phase2(phase2), .pmode(pmode), .ack(ack),
    .pend(pend), .wake_req(wake_req), .resume_isr(resume_isr)
  );

  // Reference model, built from the requirements.
  logic [NP-1:0] m_s1 = '0, m_s2 = '0, m_smp = '0, m_pend = '0;
  int m_cnt [NP];

  function automatic logic deep_m(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic [NP-1:0] held_m(input logic [1:0] m);
    logic [NP-1:0] h = '0;
    for (int i = 0; i < NP; i++) h[i] = deep_m(m) && (m_cnt[i] >= WC);
    return h;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_smp = '0; m_pend = '0;
      for (int i = 0; i < NP; i++) m_cnt[i] = 0;
    end else begin
      logic [NP-1:0] setv;
      if (deep_m(pmode))  setv = held_m(pmode) & irq_en;
      else if (phase2)    setv = m_s2 & ~m_smp;
      else                setv = '0;
      m_pend = (m_pend & ~ack) | setv;
      for (int i = 0; i < NP; i++) begin
        if (deep_m(pmode) && sfin_cfg[i] && m_s2[i]) m_cnt[i] = (m_cnt[i] < WC) ? m_cnt[i] + 1 : WC;
        else m_cnt[i] = 0;
      end
      if (deep_m(pmode) || phase2) m_smp = m_s2;
      m_s2 = m_s1;
      m_s1 = pin_raw;
    end
  end

  task automatic compare();
    logic          ew, er;
    logic [NP-1:0] h;
    h  = held_m(pmode);
    ew = deep_m(pmode) ? |h : (pmode == 2'd1) ? |(m_pend & irq_en) : 1'b0;
    er = deep_m(pmode) ? |(h & irq_en) : ew;
    vectors++;
    if (pend !== m_pend || wake_req !== ew || resume_isr !== er) begin
      miscompares++;
      $display("FAIL %s: pend=%b wake=%b resume=%b expected pend=%b wake=%b resume=%b (mode %0d t=%0t)",
               tag, pend, wake_req, resume_isr, m_pend, ew, er, pmode, $time);
    end
  endtask

  // One cycle: check at negedge, then change inputs.
  task automatic cyc(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare();
      ack = '0;
      phase2 = ~phase2;
    end
  endtask

  bit done = 0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset values held during and after reset
    tag = "R1";
    repeat (3) begin @(negedge clk); compare(); end
    rst_n = 1'b1;
    cyc(4);

    // R2: run-mode edge aligned with phase2
    tag = "R2"; pmode = 2'd0; irq_en = 4'b0001;
    @(negedge clk); pin_raw[0] = 1'b1; cyc(6);
    // R4: acknowledge and set in the same cycle
    tag = "R4"; pin_raw[0] = 1'b0; cyc(6);
    pin_raw[0] = 1'b1; cyc(2); ack = 4'b0001; cyc(1); ack = 4'b0001; cyc(4);
    ack = 4'b0001; cyc(3);
    // R3: one-cycle pulse may miss phase2
    tag = "R3"; pin_raw[1] = 1'b1; cyc(1); pin_raw[1] = 1'b0; cyc(6);
    pin_raw[2] = 1'b1; cyc(1); pin_raw[2] = 1'b0; cyc(6);

    // R8: idle wake by pending and enabled
    tag = "R8"; pmode = 2'd1; irq_en = 4'b1111; cyc(3); ack = 4'b1111; cyc(3);
    irq_en = 4'b0000; pin_raw[3] = 1'b1; cyc(6); irq_en = 4'b1000; cyc(2);
    ack = 4'b1111; pin_raw = '0; cyc(4);

    // R5: deep wake needs WAKE_CYC held cycles, enable ignored
    tag = "R5"; pmode = 2'd2; sfin_cfg = 4'b0001; irq_en = 4'b0000;
    pin_raw[0] = 1'b1; cyc(WC + 1); pin_raw[0] = 1'b0; cyc(1);
    pin_raw[0] = 1'b1; cyc(WC + 4);
    // R7: disabled wake keeps resume_isr low; then enabled sets pend
    tag = "R7"; irq_en = 4'b0001; cyc(3); pin_raw[0] = 1'b0; cyc(4);
    // R6: unconfigured pin never wakes
    tag = "R6"; pmode = 2'd3; pin_raw[1] = 1'b1; cyc(3 * WC);
    // R9: return to run with pins held high
    tag = "R9"; pmode = 2'd0; cyc(6); ack = 4'b1111; cyc(2); pin_raw = '0; cyc(4);

    // Constrained random mix
    tag = "R2,R4,R5,R7,R8";
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      compare();
      for (int i = 0; i < NP; i++) if ($urandom_range(0, 11) == 0) pin_raw[i] = ~pin_raw[i];
      ack    = ($urandom_range(0, 3) == 0) ? NP'($urandom) : '0;
      phase2 = ($urandom_range(0, 4) == 0) ? phase2 : ~phase2;
      if ($urandom_range(0, 79) == 0) pmode    = 2'($urandom);
      if ($urandom_range(0, 99) == 0) sfin_cfg = NP'($urandom);
      if ($urandom_range(0, 99) == 0) irq_en   = NP'($urandom);
    end
    cyc(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule